// File: doc/BRIEF.md
# Banked Register File with Interrupt Bank Swap

This block is the general-purpose register file of a small 4-bit processor. It stores 24 physical 4-bit registers. Software sees 16 logical registers at a time. Logical registers 8 to 15 always name the same eight shared physical registers. Logical registers 0 to 7 name one of two switchable banks of eight physical registers. A bank-select command from the decoder chooses which bank is in use.

The control unit pulses a strobe when it takes an interrupt. On that strobe the file changes to the other bank by itself, so the handler cannot disturb the low registers of the interrupted program. No save instructions are needed. The file keeps the bank that was active before entry. A return strobe puts that bank back.

The file has two combinational read ports and one write port, all addressed by a 4-bit logical index. A status output shows which bank is selected now.

Top module: `banked_regfile`

## Requirements
- R1: While `rst_n` is low, and after it is released, bank 0 is selected (`bank_status` = 0) and every physical register reads as zero.
- R2: Both read ports are combinational from the registered state. A read of a register that is being written in the same cycle returns the value held before that write; there is no write-through.
- R3: When `wr_en` is high at a rising edge, `wr_data` is stored in the physical register that `wr_idx` maps to. From the next cycle on, the value can be read through either port.
- R4: Logical indices 8 to 15 reach the same eight physical registers whichever bank is selected.
- R5: Logical indices 0 to 7 reach the eight registers of the selected bank. Bank 0 and bank 1 are separate storage. A `bank_cmd_valid` pulse selects the bank given by `bank_cmd_sel` (0 = bank 0, 1 = bank 1) from the next cycle on. With no command and no interrupt strobe, the selection does not change.
- R6: An `irq_enter` pulse records the current bank and selects the other bank from the next cycle on. The low registers of the interrupted bank keep their values. Only one level is recorded: a second entry overwrites the recorded bank.
- R7: An `irq_return` pulse selects, from the next cycle on, the bank recorded by the latest `irq_enter`.
- R8: When several bank events arrive in one cycle, `irq_enter` wins over `irq_return`, and `irq_return` wins over `bank_cmd_valid`. A write in the same cycle as a bank change goes to the bank that was selected before the change.
- R9: `bank_status` always equals the index of the bank that logical registers 0 to 7 currently reach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | 4 | Read data of port A |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | 4 | Read data of port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical index to write |
| wr_data | input | 4 | Data to write |
| bank_cmd_valid | input | 1 | Bank-select command strobe |
| bank_cmd_sel | input | 1 | Bank chosen by the command |
| irq_enter | input | 1 | Interrupt-entry strobe |
| irq_return | input | 1 | Return-from-interrupt strobe |
| bank_status | output | 1 | Currently selected bank |

## Verification
The assertions check the following on every cycle:
- the bank transitions: entry toggles the bank, return restores the recorded bank, a command loads its value, and the bank holds when nothing happens;
- the event priority;
- the reset state;
- that a write to a shared register, or a write with the bank unchanged, reads back one cycle later.

Some behaviour only the bench scenarios can show. These are that the two low banks really are separate storage, that the interrupted context survives a full handler that rewrites its low registers, and that a write in the same cycle as a bank change lands in the old bank. The bench shows them by comparing both read ports against a behavioural model over whole sequences.

// File: rtl/rf_bank_pkg.sv
package rf_bank_pkg;

    // Which bank event wins in a cycle (priority already resolved)
    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_ENTER  = 2'd1,
        EV_RETURN = 2'd2,
        EV_CMD    = 2'd3
    } bank_event_e;

    // Bank selection state
    typedef struct packed {
        logic cur;     // bank currently mapped to the low logical registers
        logic saved;   // bank recorded at interrupt entry
    } bank_state_t;

endpackage

// File: rtl/rf_bank_ctrl.sv
module rf_bank_ctrl
    import rf_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_enter,
    input  logic irq_return,
    input  logic cmd_valid,
    input  logic cmd_sel,
    output logic bank_q
);

    bank_state_t state_d, state_q;
    bank_event_e ev;

    always_comb begin
        // Priority: entry, then return, then command
        if (irq_enter)       ev = EV_ENTER;
        else if (irq_return) ev = EV_RETURN;
        else if (cmd_valid)  ev = EV_CMD;
        else                 ev = EV_NONE;

        state_d = state_q;
        case (ev)
            EV_ENTER: begin
                state_d.saved = state_q.cur;
                state_d.cur   = ~state_q.cur;
            end
            EV_RETURN: state_d.cur = state_q.saved;
            EV_CMD:    state_d.cur = cmd_sel;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bank_q = state_q.cur;

endmodule

// File: rtl/rf_addr_map.sv
module rf_addr_map #(
    parameter int IDX_W     = 4,
    parameter int PIDX_W    = 5,
    parameter int BANK_REGS = 8
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              bank,
    output logic [PIDX_W-1:0] phys
);

    // Physical layout: bank 0 low, bank 1 low, then shared registers
    localparam logic [PIDX_W-1:0] BANK1_BASE  = PIDX_W'(BANK_REGS);
    localparam logic [PIDX_W-1:0] SHARED_BASE = PIDX_W'(2 * BANK_REGS);
    localparam logic [IDX_W-1:0]  SPLIT       = IDX_W'(BANK_REGS);

    always_comb begin
        if (idx < SPLIT)
            phys = (bank ? BANK1_BASE : '0) + PIDX_W'(idx);
        else
            phys = SHARED_BASE + PIDX_W'(idx - SPLIT);
    end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int DATA_W    = 4,
    parameter int PHYS_REGS = 24,
    parameter int PIDX_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PIDX_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PIDX_W-1:0] raddr_a,
    input  logic [PIDX_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] regs_d [PHYS_REGS];
    logic [DATA_W-1:0] regs_q [PHYS_REGS];

    always_comb begin
        regs_d = regs_q;
        if (we) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_REGS; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Reads see registered state only: old value on a same-cycle write
    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
    parameter int DATA_W    = 4,
    parameter int LOG_REGS  = 16,
    parameter int BANK_REGS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(LOG_REGS)-1:0] rd_a_idx,
    output logic [DATA_W-1:0]           rd_a_data,
    input  logic [$clog2(LOG_REGS)-1:0] rd_b_idx,
    output logic [DATA_W-1:0]           rd_b_data,
    input  logic                        wr_en,
    input  logic [$clog2(LOG_REGS)-1:0] wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        bank_cmd_valid,
    input  logic                        bank_cmd_sel,
    input  logic                        irq_enter,
    input  logic                        irq_return,
    output logic                        bank_status
);

    localparam int IDX_W     = $clog2(LOG_REGS);
    localparam int PHYS_REGS = LOG_REGS + BANK_REGS;
    localparam int PIDX_W    = $clog2(PHYS_REGS);
    localparam int N_PORTS   = 3;   // read A, read B, write

    logic              bank_q;
    logic [IDX_W-1:0]  port_idx  [N_PORTS];
    logic [PIDX_W-1:0] port_phys [N_PORTS];

    assign port_idx[0] = rd_a_idx;
    assign port_idx[1] = rd_b_idx;
    assign port_idx[2] = wr_idx;

    rf_bank_ctrl u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_enter  (irq_enter),
        .irq_return (irq_return),
        .cmd_valid  (bank_cmd_valid),
        .cmd_sel    (bank_cmd_sel),
        .bank_q     (bank_q)
    );

    for (genvar p = 0; p < N_PORTS; p++) begin : g_map
        rf_addr_map #(
            .IDX_W     (IDX_W),
            .PIDX_W    (PIDX_W),
            .BANK_REGS (BANK_REGS)
        ) u_map (
            .idx  (port_idx[p]),
            .bank (bank_q),
            .phys (port_phys[p])
        );
    end

    rf_storage #(
        .DATA_W    (DATA_W),
        .PHYS_REGS (PHYS_REGS),
        .PIDX_W    (PIDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (port_phys[2]),
        .wdata   (wr_data),
        .raddr_a (port_phys[0]),
        .raddr_b (port_phys[1]),
        .rdata_a (rd_a_data),
        .rdata_b (rd_b_data)
    );

    assign bank_status = bank_q;

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
    parameter int DATA_W    = 4,
    parameter int LOG_REGS  = 16,
    parameter int BANK_REGS = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [$clog2(LOG_REGS)-1:0] rd_a_idx,
    input logic [DATA_W-1:0]           rd_a_data,
    input logic [$clog2(LOG_REGS)-1:0] rd_b_idx,
    input logic [DATA_W-1:0]           rd_b_data,
    input logic                        wr_en,
    input logic [$clog2(LOG_REGS)-1:0] wr_idx,
    input logic [DATA_W-1:0]           wr_data,
    input logic                        bank_cmd_valid,
    input logic                        bank_cmd_sel,
    input logic                        irq_enter,
    input logic                        irq_return,
    input logic                        bank_status
);

    localparam int IDX_W = $clog2(LOG_REGS);
    localparam logic [IDX_W-1:0] SPLIT = IDX_W'(BANK_REGS);

    // Bank seen at the last entry, observed at the ports
    logic entry_bank;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         entry_bank <= 1'b0;
        else if (irq_enter) entry_bank <= bank_status;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |-> (bank_status == 1'b0 && rd_a_data == '0 && rd_b_data == '0));

    p_cmd_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_cmd_valid && !irq_enter && !irq_return) |=> bank_status == $past(bank_cmd_sel));

    p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_cmd_valid && !irq_enter && !irq_return) |=> $stable(bank_status));

    p_enter_toggles_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> bank_status != $past(bank_status));

    p_return_restores_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_enter) |=> bank_status == $past(entry_bank));

    // R8: entry wins even when a command asks for the current bank
    p_enter_beats_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_enter && bank_cmd_valid && bank_cmd_sel == bank_status) |=> bank_status != $past(bank_status));

    // R3 / R4: written value reads back on port A next cycle
    p_write_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en ##1 (rd_a_idx == $past(wr_idx) && (rd_a_idx >= SPLIT || $stable(bank_status)))
        |-> rd_a_data == $past(wr_data));

endmodule

bind banked_regfile banked_regfile_chk #(
    .DATA_W    (DATA_W),
    .LOG_REGS  (LOG_REGS),
    .BANK_REGS (BANK_REGS)
) u_chk (.*);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, wr_data = '0;
    logic       wr_en = 1'b0, bank_cmd_valid = 1'b0, bank_cmd_sel = 1'b0;
    logic       irq_enter = 1'b0, irq_return = 1'b0;
    logic [3:0] rd_a_data, rd_b_data;
    logic       bank_status;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    banked_regfile uut (.*);

    // Behavioural reference model
    logic [3:0] m_low [2][8];
    logic [3:0] m_shared [8];
    logic       m_bank, m_saved;

    task automatic model_clear();
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 8; i++) m_low[b][i] = '0;
        for (int i = 0; i < 8; i++) m_shared[i] = '0;
        m_bank = 1'b0;
        m_saved = 1'b0;
    endtask

    function automatic logic [3:0] m_read(input logic [3:0] idx);
        if (idx < 8) return m_low[m_bank][idx[2:0]];
        return m_shared[idx[2:0]];
    endfunction

    task automatic cmp(input string tag, input string what, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // One cycle: compare before the edge, update model at the edge
    task automatic step(input string tag);
        if (!rst_n) model_clear();
        @(negedge clk);
        cmp(tag, "port A", rd_a_data, m_read(rd_a_idx));
        cmp(tag, "port B", rd_b_data, m_read(rd_b_idx));
        cmp(tag, "bank status", {3'b0, bank_status}, {3'b0, m_bank});
        @(posedge clk);
        if (rst_n) begin
            if (wr_en) begin
                if (wr_idx < 8) m_low[m_bank][wr_idx[2:0]] = wr_data;
                else            m_shared[wr_idx[2:0]] = wr_data;
            end
            if (irq_enter) begin
                m_saved = m_bank;
                m_bank = ~m_bank;
            end else if (irq_return) begin
                m_bank = m_saved;
            end else if (bank_cmd_valid) begin
                m_bank = bank_cmd_sel;
            end
        end
        #1;
    endtask

    task automatic quiet();
        wr_en = 0; bank_cmd_valid = 0; irq_enter = 0; irq_return = 0;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [3:0] d, input string tag);
        quiet();
        wr_en = 1; wr_idx = idx; wr_data = d;
        step(tag);
        quiet();
    endtask

    task automatic sweep(input string tag);
        quiet();
        for (int i = 0; i < 16; i += 2) begin
            rd_a_idx = 4'(i); rd_b_idx = 4'(i + 1);
            step(tag);
        end
    endtask

    task automatic ev(input logic ent, input logic ret, input logic cv, input logic cs, input string tag);
        quiet();
        irq_enter = ent; irq_return = ret; bank_cmd_valid = cv; bank_cmd_sel = cs;
        step(tag);
        quiet();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_clear();
        // R1: reset state
        rst_n = 0;
        repeat (3) step("R1");
        rst_n = 1;
        sweep("R1");

        // R3 / R2: fill bank 0 and shared registers
        for (int i = 0; i < 16; i++) wr(4'(i), 4'(i + 1), "R3");
        sweep("R3");

        // R2: same-cycle read of the written register returns old value
        rd_a_idx = 4'd5; rd_b_idx = 4'd12;
        wr(4'd5, 4'hA, "R2");
        rd_a_idx = 4'd12;
        wr(4'd12, 4'hB, "R2");
        sweep("R2");

        // R5 / R9 / R4: select bank 1; low registers fresh, shared unchanged
        ev(0, 0, 1, 1, "R9");
        sweep("R4");
        for (int i = 0; i < 8; i++) wr(4'(i), 4'(15 - i), "R5");
        sweep("R5");
        ev(0, 0, 1, 0, "R5");
        sweep("R5");
        ev(0, 0, 0, 0, "R5");

        // R6 / R7: entry from bank 0, handler overwrites low registers
        ev(1, 0, 0, 0, "R6");
        sweep("R6");
        for (int i = 0; i < 8; i++) wr(4'(i), 4'(i ^ 3), "R6");
        wr(4'd9, 4'h7, "R4");
        ev(0, 1, 0, 0, "R7");
        sweep("R7");

        // R6 / R7: entry from bank 1 goes to bank 0
        ev(0, 0, 1, 1, "R5");
        ev(1, 0, 0, 0, "R6");
        sweep("R6");
        ev(0, 1, 0, 0, "R7");
        sweep("R7");

        // R8: priorities
        ev(1, 1, 1, 1, "R8");
        ev(0, 0, 0, 0, "R8");
        ev(0, 1, 1, 0, "R8");
        ev(0, 0, 0, 0, "R8");
        ev(1, 0, 1, 0, "R8");
        ev(0, 0, 0, 0, "R8");

        // R8: write during a bank change lands in the old bank
        quiet();
        wr_en = 1; wr_idx = 4'd2; wr_data = 4'hE; bank_cmd_valid = 1; bank_cmd_sel = ~bank_status;
        step("R8");
        quiet();
        sweep("R8");
        ev(0, 0, 1, ~bank_status, "R8");
        sweep("R8");
        wr_en = 1; wr_idx = 4'd3; wr_data = 4'hD; irq_enter = 1;
        step("R8");
        quiet();
        sweep("R8");
        ev(0, 1, 0, 0, "R7");
        sweep("R8");

        // R1: reset in the middle of operation
        rst_n = 0;
        step("R1");
        rst_n = 1;
        sweep("R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule